// File: doc/BRIEF.md
# Prewitt Gradient Magnitude Pipeline

This block takes one complete 3x3 neighbourhood of unsigned pixels per clock and returns the edge strength at its centre. It forms the two Prewitt gradients, one along each axis. The masks hold only +1, 0 and -1, so each gradient is a difference of two three-pixel sums, built from adders and no multipliers. The block then squares both gradients, adds them and takes the integer square root of the sum, rounded down. The root uses a restoring digit-by-digit method, and each pipeline stage settles one bit of the result.

The datapath is fully pipelined. A new window can enter on every clock, and a result leaves a fixed number of cycles later. A cycle with the input strobe low is a bubble. It travels down the pipeline as an empty slot and never turns into an output. The neighbouring winder sit either side of the bubble are not affected. The block does not form windows, handle image borders or access memory; an upstream line buffer supplies those.

Top module: `prewitt_mag`

## Requirements
- R1: Port `win` carries nine unsigned 8-bit pixels. Pixel (row r, column c), with r and c in 0..2 and row 0 on top, sits at bits [8*(3r+c)+7 : 8*(3r+c)].
- R2: The vertical gradient dy equals the sum of row 2 minus the sum of row 0, a value in -765..765.
- R3: The horizontal gradient dx equals the sum of column 2 minus the sum of column 0, a value in -765..765.
- R4: For every accepted window, `out_mag` equals floor(sqrt(dx*dx + dy*dy)) as a non-negative 16-bit signed value; the largest result the masks can produce is below 1082.
- R5: A window accepted on a clock edge with `in_valid` high produces `out_valid` high for exactly one cycle, 15 cycles later. Back-to-back windows produce back-to-back results in order.
- R6: A cycle with `in_valid` low produces no result, and it does not change the results of the windows before or after it.
- R7: Reset is synchronous and active high. While it is applied and in the cycle after it, `out_valid` is 0 and `out_mag` is 0. Windows in flight when reset arrives produce no result.
- R8: When `out_valid` is low, `out_mag` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window on `win` is accepted this cycle |
| win | input | 72 | Nine packed pixels, layout as in R1 |
| out_valid | output | 1 | `out_mag` carries a new result |
| out_mag | output | 16 | Gradient magnitude, signed, never negative |

## Verification
The bench aims at the root near perfect squares and at the largest gradients of both signs. A root stage with a wrong comparison would be off by one exactly where the sum equals k*k or k*k-1. A gradient with a sign error would show up on windows whose dx or dy is -765. Random streams with random bubbles and a reset that arrives in mid-stream catch the failures a slip in valid tracking causes: an output shifted by one cycle, a bubble that comes out as a result, a result dropped after a gap, or a window from before reset leaking out. A model of the masks, built with coefficient weights, and a search-based square root give the expected values.

// File: rtl/prewitt_pkg.sv
package prewitt_pkg;

  localparam int PIX_W_DEF = 8;
  localparam int OUT_W_DEF = 16;

  // register stages ahead of the root: line sums, differences, squares, sum
  localparam int FRONT_STAGES = 4;

  // bits of an integer root of a rad_w-bit radicand
  function automatic int root_bits(input int rad_w);
    return (rad_w + 1) / 2;
  endfunction

  // cycles from an accepted window to its result
  function automatic int pipe_latency(input int root_w);
    return FRONT_STAGES + root_w;
  endfunction

endpackage

// File: rtl/prewitt_grad.sv
module prewitt_grad #(
  parameter int PIX_W  = 8,
  parameter int SUMC_W = PIX_W + 2,
  parameter int GRAD_W = SUMC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [9*PIX_W-1:0]       win,
  output logic                     g_valid,
  output logic signed [GRAD_W-1:0] dx,
  output logic signed [GRAD_W-1:0] dy
);

  function automatic logic [PIX_W-1:0] pix_at(input logic [9*PIX_W-1:0] w,
                                              input int r, input int c);
    return w[PIX_W*(3*r+c) +: PIX_W];
  endfunction

  // sum of one row (along_row=1) or one column (along_row=0)
  function automatic logic [SUMC_W-1:0] line_sum(input logic [9*PIX_W-1:0] w,
                                                 input logic along_row, input int idx);
    logic [SUMC_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < 3; k++) begin
      if (along_row) acc = acc + SUMC_W'(pix_at(w, idx, k));
      else           acc = acc + SUMC_W'(pix_at(w, k, idx));
    end
    return acc;
  endfunction

  function automatic logic signed [GRAD_W-1:0] diff(input logic [SUMC_W-1:0] plus_side,
                                                    input logic [SUMC_W-1:0] minus_side);
    return $signed({1'b0, plus_side}) - $signed({1'b0, minus_side});
  endfunction

  // stage A: four line sums (zero mask row/column dropped)
  logic              va;
  logic [SUMC_W-1:0] top_q, bot_q, lft_q, rgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0;
    end else begin
      va <= in_valid;
      if (in_valid) begin
        top_q <= line_sum(win, 1'b1, 0);
        bot_q <= line_sum(win, 1'b1, 2);
        lft_q <= line_sum(win, 1'b0, 0);
        rgt_q <= line_sum(win, 1'b0, 2);
      end
    end
  end

  // stage B: negated side feeds the subtractor
  always_ff @(posedge clk) begin
    if (rst) begin
      g_valid <= 1'b0;
    end else begin
      g_valid <= va;
      if (va) begin
        dy <= diff(bot_q, top_q);
        dx <= diff(rgt_q, lft_q);
      end
    end
  end

endmodule

// File: rtl/prewitt_sumsq.sv
module prewitt_sumsq #(
  parameter int GRAD_W = 11,
  parameter int MAG_W  = GRAD_W - 1,
  parameter int SQ_W   = 2 * MAG_W,
  parameter int RAD_W  = SQ_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     g_valid,
  input  logic signed [GRAD_W-1:0] dx,
  input  logic signed [GRAD_W-1:0] dy,
  output logic                     s_valid,
  output logic [RAD_W-1:0]         rad
);

  function automatic logic [MAG_W-1:0] abs_mag(input logic signed [GRAD_W-1:0] g);
    logic [GRAD_W-1:0] u;
    u = g[GRAD_W-1] ? GRAD_W'(-g) : GRAD_W'(g);
    return u[MAG_W-1:0];
  endfunction

  function automatic logic [SQ_W-1:0] square(input logic [MAG_W-1:0] a);
    return SQ_W'(a) * SQ_W'(a);
  endfunction

  logic            vq;
  logic [SQ_W-1:0] sqx_q, sqy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= 1'b0;
    end else begin
      vq <= g_valid;
      if (g_valid) begin
        sqx_q <= square(abs_mag(dx));
        sqy_q <= square(abs_mag(dy));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
    end else begin
      s_valid <= vq;
      if (vq) rad <= RAD_W'(sqx_q) + RAD_W'(sqy_q);
    end
  end

endmodule

// File: rtl/prewitt_isqrt.sv
module prewitt_isqrt #(
  parameter int RAD_W  = 21,
  parameter int ROOT_W = (RAD_W + 1) / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [RAD_W-1:0]  rad,
  output logic              r_valid,
  output logic [ROOT_W-1:0] root,
  output logic [RAD_W-1:0]  rem_out
);

  localparam int EXT_W = 2 * ROOT_W + 1;

  // amount removed from the remainder if bit b of the root is set:
  // (r + 2^b)^2 - r^2 = r*2^(b+1) + 2^(2b), with r holding only bits above b
  function automatic logic [EXT_W-1:0] trial_term(input logic [ROOT_W-1:0] r, input int b);
    return (EXT_W'(r) << (b + 1)) + (EXT_W'(1) << (2 * b));
  endfunction

  for (genvar k = 0; k < ROOT_W; k++) begin : g_stage
    localparam int B = ROOT_W - 1 - k;
    logic              v_in;
    logic [RAD_W-1:0]  rem_in;
    logic [ROOT_W-1:0] root_in;
    logic [EXT_W-1:0]  t;
    logic              take;
    logic              v_q;
    logic [RAD_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;

    if (k == 0) begin : g_head
      assign v_in    = s_valid;
      assign rem_in  = rad;
      assign root_in = '0;
    end else begin : g_link
      assign v_in    = g_stage[k-1].v_q;
      assign rem_in  = g_stage[k-1].rem_q;
      assign root_in = g_stage[k-1].root_q;
    end

    assign t    = trial_term(root_in, B);
    assign take = (EXT_W'(rem_in) >= t);

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q    <= 1'b0;
        rem_q  <= '0;
        root_q <= '0;
      end else begin
        v_q <= v_in;
        if (v_in) begin
          rem_q  <= take ? RAD_W'(EXT_W'(rem_in) - t) : rem_in;
          root_q <= take ? (root_in | (ROOT_W'(1) << B)) : root_in;
        end
      end
    end
  end

  assign r_valid = g_stage[ROOT_W-1].v_q;
  assign root    = g_stage[ROOT_W-1].root_q;
  assign rem_out = g_stage[ROOT_W-1].rem_q;

endmodule

// File: rtl/prewitt_mag.sv
module prewitt_mag
  import prewitt_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  parameter int OUT_W = OUT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [9*PIX_W-1:0] win,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_mag
);

  localparam int SUMC_W = PIX_W + 2;
  localparam int GRAD_W = SUMC_W + 1;
  localparam int SQ_W   = 2 * SUMC_W;
  localparam int RAD_W  = SQ_W + 1;
  localparam int ROOT_W = root_bits(RAD_W);
  localparam int LAT    = pipe_latency(ROOT_W);

  // named internal events, observed by the bound checker
  logic                     g_valid;
  logic signed [GRAD_W-1:0] dx, dy;
  logic                     s_valid;
  logic [RAD_W-1:0]         rad;
  logic                     r_valid;
  logic [ROOT_W-1:0]        root;
  logic [RAD_W-1:0]         rem_out;

  prewitt_grad #(.PIX_W(PIX_W), .SUMC_W(SUMC_W), .GRAD_W(GRAD_W)) u_grad (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win(win),
    .g_valid(g_valid), .dx(dx), .dy(dy)
  );

  prewitt_sumsq #(.GRAD_W(GRAD_W), .MAG_W(SUMC_W), .SQ_W(SQ_W), .RAD_W(RAD_W)) u_sumsq (
    .clk(clk), .rst(rst), .g_valid(g_valid), .dx(dx), .dy(dy),
    .s_valid(s_valid), .rad(rad)
  );

  prewitt_isqrt #(.RAD_W(RAD_W), .ROOT_W(ROOT_W)) u_isqrt (
    .clk(clk), .rst(rst), .s_valid(s_valid), .rad(rad),
    .r_valid(r_valid), .root(root), .rem_out(rem_out)
  );

  assign out_valid = r_valid;
  assign out_mag   = OUT_W'(root);

endmodule

// File: rtl/prewitt_mag_chk.sv
module prewitt_mag_chk #(
  parameter int PIX_W  = 8,
  parameter int OUT_W  = 16,
  parameter int GRAD_W = 11,
  parameter int RAD_W  = 21,
  parameter int LAT    = 15
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic [OUT_W-1:0]         out_mag,
  input logic                     g_valid,
  input logic signed [GRAD_W-1:0] dx,
  input logic signed [GRAD_W-1:0] dy,
  input logic [RAD_W-1:0]         rem_out
);

  localparam int MAXG = 3 * ((1 << PIX_W) - 1);
  localparam int WW   = OUT_W + 2;

  logic [LAT-1:0] shadow;
  logic           rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) shadow <= '0;
    else     shadow <= {shadow[LAT-2:0], in_valid};
  end

  logic [WW-1:0] two_root;
  assign two_root = {1'b0, out_mag, 1'b0};

  p_dy_range_r2: assert property (@(posedge clk) disable iff (rst)
    g_valid |-> (dy >= -MAXG && dy <= MAXG));

  p_dx_range_r3: assert property (@(posedge clk) disable iff (rst)
    g_valid |-> (dx >= -MAXG && dx <= MAXG));

  // floor root: leftover radicand never reaches (r+1)^2 - r^2
  p_root_floor_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (WW'(rem_out) <= two_root && !out_mag[OUT_W-1]));

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid == shadow[LAT-1]);

  p_no_bubble_out_r6: assert property (@(posedge clk) disable iff (rst)
    !shadow[LAT-1] |-> !out_valid);

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_mag == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst || rst_q)
    !out_valid |-> $stable(out_mag));

endmodule

bind prewitt_mag prewitt_mag_chk #(
  .PIX_W(PIX_W), .OUT_W(OUT_W), .GRAD_W(GRAD_W), .RAD_W(RAD_W), .LAT(LAT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_mag(out_mag), .g_valid(g_valid), .dx(dx), .dy(dy), .rem_out(rem_out)
);

// File: tb/sim_prewitt_mag.sv
`timescale 1ns/1ps
module sim_prewitt_mag;

  localparam int LATENCY = 15;

  typedef struct { int mag; longint cyc; } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [71:0] win = '0;
  logic        out_valid;
  logic [15:0] out_mag;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint cyc     = 0;
  exp_t   q[$];
  logic [15:0] last_mag = '0;
  string  cur_req = "R4";
  bit     done = 1'b0;

  prewitt_mag u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win(win),
    .out_valid(out_valid), .out_mag(out_mag)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // model: masks as coefficient weights, root by upward search
  function automatic int model_mag(input logic [71:0] w);
    int gx, gy, s, r, p;
    gx = 0; gy = 0;
    for (int rr = 0; rr < 3; rr++)
      for (int cc = 0; cc < 3; cc++) begin
        p  = int'(w[8*(3*rr+cc) +: 8]);
        gx = gx + (cc - 1) * p;
        gy = gy + (rr - 1) * p;
      end
    s = gx * gx + gy * gy;
    r = 0;
    while ((r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  function automatic logic [71:0] mk(input int p0, p1, p2, p3, p4, p5, p6, p7, p8);
    logic [71:0] w;
    w = {8'(p8), 8'(p7), 8'(p6), 8'(p5), 8'(p4), 8'(p3), 8'(p2), 8'(p1), 8'(p0)};
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [71:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1;
    win = w;
    q.push_back('{model_mag(w), cyc});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      win = {$urandom, $urandom, 8'($urandom)};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      last_mag = '0;
    end else if (!done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R6", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.cyc + LATENCY, "R5", "result cycle", cyc, e.cyc + LATENCY);
          check(int'(out_mag) == e.mag, cur_req, "magnitude", out_mag, e.mag);
        end
        last_mag = out_mag;
      end else begin
        check(out_mag == last_mag, "R8", "idle hold", out_mag, last_mag);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_mag == 16'd0, "R7", "reset state", out_mag, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    idle(3);

    // R1 R2 R3 R4: directed windows
    cur_req = "R4";
    send(mk(0,0,0, 0,0,0, 0,0,0));                 // 0
    send(mk(255,255,255, 255,255,255, 255,255,255)); // flat -> 0
    send(mk(0,0,255, 0,0,255, 0,0,255));           // R3 dx=+765
    send(mk(255,0,0, 255,0,0, 255,0,0));           // R3 dx=-765
    send(mk(0,0,0, 0,0,0, 255,255,255));           // R2 dy=+765
    send(mk(255,255,255, 0,0,0, 0,0,0));           // R2 dy=-765
    send(mk(0,0,0, 0,0,3, 0,4,0));                 // R1 dx=3 dy=4 -> 5
    send(mk(0,4,0, 3,0,0, 0,0,0));                 // dx=-3 dy=-4 -> 5
    send(mk(0,0,200, 0,0,255, 200,255,255));       // large diagonal
    send(mk(0,0,0, 0,0,1, 0,0,0));                 // sum 1 -> 1
    send(mk(0,0,1, 0,0,1, 0,0,0));                 // dx=2 dy=-1 -> 2
    send(mk(0,0,0, 0,17,0, 0,0,0));                // centre ignored -> 0
    idle(20);

    // R5: back-to-back random stream
    for (int i = 0; i < 2000; i++)
      send({$urandom, $urandom, 8'($urandom)});
    idle(20);

    // R6: random stream with bubbles
    cur_req = "R6";
    for (int i = 0; i < 1000; i++) begin
      send({$urandom, $urandom, 8'($urandom)});
      if ($urandom_range(2) == 0) idle($urandom_range(3, 1));
    end
    idle(20);
    check(q.size() == 0, "R5", "results outstanding", q.size(), 0);

    // R7: reset in mid-stream discards windows in flight
    cur_req = "R4";
    for (int i = 0; i < 6; i++) send({$urandom, $urandom, 8'($urandom)});
    @(posedge clk); #1;
    in_valid = 1'b0;
    rst = 1'b1;
    q.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_mag == 16'd0, "R7", "mid-stream reset", out_mag, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    idle(25);
    send(mk(0,0,255, 0,0,255, 0,0,255));
    idle(20);
    check(q.size() == 0, "R7", "result after reset", q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule